// File: doc/BRIEF.md
# DMA Channel Trigger Pacing Unit

This block decides when one DMA channel may hand work to its data mover. It watches an asynchronous hardware trigger, an optional peripheral request line and a channel enable. An 8-bit configuration word selects how they combine. Once a trigger event is accepted, the block holds a transfer request towards the mover and counts the mover's completion pulses. The count is either one transfer or a power-of-two burst. When the last transfer of the unit completes, it emits a single-cycle completion pulse.

The trigger is first brought into the clock domain. It is then read as a level or as an edge of either sense. An edge that arrives while a burst is still in flight is held as one pending event, so it is not lost. Addressing, bus access, descriptor handling and arbitration between channels belong to other blocks.

Top module: `dma_pace_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `xferReq` and `burstDone` are low, and no trigger event is pending.
- R2: With the trigger disabled (`cfgWord[1]`=0), a new unit of work starts on every idle cycle in which `chanEnable` is high. No unit starts while `chanEnable` is low.
- R3: With `cfgWord[0]`=1, `xferReq` is high only while a unit is running and `perReq` is high. With `cfgWord[0]`=0, `perReq` has no effect and `xferReq` is high for the whole running unit.
- R4: With `cfgWord[1]`=0, the value and the changes of `hwTrig` have no effect on the outputs.
- R5: In edge mode (`cfgWord[3]`=0, `cfgWord[1]`=1), `cfgWord[2]`=1 selects a rising edge of `hwTrig` and `cfgWord[2]`=0 selects a falling edge. When the channel is idle and enabled, `xferReq` rises after the third rising clock edge following the input change. No trigger event is recognised during the first three clock edges after reset.
- R6: In level mode (`cfgWord[3]`=1, `cfgWord[1]`=1), a unit starts on any idle, enabled cycle in which the synchronised trigger is at its active level: high if `cfgWord[2]`=1, low otherwise. Units keep restarting while that level holds.
- R7: With `cfgWord[4]`=1, a unit is 2^N transfers, where N=`cfgWord[7:5]` (N=7 gives 128). With `cfgWord[4]`=0, a unit is exactly one transfer. The length is taken from the configuration in the cycle the unit starts.
- R8: `burstDone` is high for exactly one cycle: the cycle after the clock edge that samples the unit's last `xferDone`. In that cycle `xferReq` is low. The next unit can start at the following edge.
- R9: An edge event that is not consumed by a start is held as pending. At most one event is held. A pending event starts the next unit as soon as the channel is idle and enabled. An edge that arrives together with a start is absorbed by that start.
- R10: `xferDone` pulses while no unit is running change neither the outputs nor the length of the next unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chanEnable | input | 1 | Software channel enable; permits new units to start |
| cfgWord | input | 8 | [0] request pacing, [1] trigger enable, [2] polarity, [3] level mode, [4] burst mode, [7:5] burst exponent |
| perReq | input | 1 | Peripheral request line used for pacing |
| hwTrig | input | 1 | Asynchronous hardware trigger |
| xferDone | input | 1 | One pulse per completed transfer from the mover |
| xferReq | output | 1 | Transfer request to the mover |
| burstDone | output | 1 | One-cycle pulse when a unit of work completes |

## Verification
The delicate overlaps are a new trigger edge that becomes visible in the same cycle as the last `xferDone` of a running burst, and the completion of one unit in the same window as the conditions for the next start. The bench provokes the first on purpose. It stalls the mover, issues a second edge during the burst, and then releases the mover, so that the pending event must start exactly one extra burst. Randomised segments with sparse trigger toggles and a mover that completes at random then land edges on completion cycles many times. Every cycle is compared against a cycle model kept in the bench. Directed counts of transfers and completion pulses give independent expected totals.

// File: rtl/pace_pkg.sv
package pace_pkg;

  localparam int CFG_W = 8;
  localparam int EXP_W = 3;

  // Configuration word, most significant field first.
  typedef struct packed {
    logic [EXP_W-1:0] burstExp;
    logic             burstMode;
    logic             levelMode;
    logic             polHigh;
    logic             trigEn;
    logic             reqEn;
  } paceCfg_t;

  // Strobes from control to the counting datapath.
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } ctrlStrobe_t;

  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_MOVE = 1'b1
  } paceState_t;

endpackage

// File: rtl/pace_trig.sv
module pace_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hwTrig,
  input  logic polHigh,
  output logic trigActive,
  output logic trigEdge
);

  localparam int PRIME_MAX = SYNC_STAGES + 1;
  localparam int PRIME_W   = $clog2(PRIME_MAX + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [PRIME_W-1:0]     primeCnt;
  logic                   primed;
  logic                   syncOut;
  logic                   riseSeen;
  logic                   fallSeen;

  // Synchroniser chain, history flop and warm-up counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ    <= '0;
      prevQ    <= 1'b0;
      primeCnt <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], hwTrig};
      prevQ <= syncQ[SYNC_STAGES-1];
      if (primeCnt != PRIME_W'(PRIME_MAX)) begin
        primeCnt <= primeCnt + PRIME_W'(1);
      end
    end
  end

  always_comb begin
    primed     = (primeCnt == PRIME_W'(PRIME_MAX));
    syncOut    = syncQ[SYNC_STAGES-1];
    riseSeen   = syncOut & ~prevQ;
    fallSeen   = ~syncOut & prevQ;
    trigActive = primed & (polHigh ? syncOut : ~syncOut);
    trigEdge   = primed & (polHigh ? riseSeen : fallSeen);
  end

  // R5
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    trigEdge |=> !trigEdge);

endmodule

// File: rtl/pace_count.sv
module pace_count
  import pace_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int XP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic              burstMode,
  input  logic [XP_W-1:0]   burstExp,
  output logic              cntZero
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   spanW;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    spanW   = (CNT_W+1)'(1) << burstExp;
    loadVal = burstMode ? CNT_W'(spanW - (CNT_W+1)'(1)) : '0;
    cntZero = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (strobe.loadCnt) begin
      cnt <= loadVal;
    end else if (strobe.decCnt) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.decCnt |-> (cnt != '0));

endmodule

// File: rtl/pace_ctrl.sv
module pace_ctrl
  import pace_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        chanEnable,
  input  logic        reqEn,
  input  logic        trigEn,
  input  logic        levelMode,
  input  logic        perReq,
  input  logic        xferDone,
  input  logic        trigActive,
  input  logic        trigEdge,
  input  logic        cntZero,
  output ctrlStrobe_t strobe,
  output logic        xferReq,
  output logic        burstDone
);

  paceState_t state, stateNext;
  logic       running;
  logic       pending, pendNext;
  logic       doneQ;
  logic       trigOk;
  logic       startNow;
  logic       lastXfer;

  always_comb begin
    running = (state == PS_MOVE);
    if (!trigEn) begin
      trigOk = 1'b1;
    end else if (levelMode) begin
      trigOk = trigActive;
    end else begin
      trigOk = trigEdge | pending;
    end
    startNow = ~running & chanEnable & trigOk;
    lastXfer = running & xferDone & cntZero;

    strobe.loadCnt = startNow;
    strobe.decCnt  = running & xferDone & ~cntZero;

    stateNext = state;
    if (startNow) begin
      stateNext = PS_MOVE;
    end else if (lastXfer) begin
      stateNext = PS_IDLE;
    end

    if (!trigEn || levelMode) begin
      pendNext = 1'b0;
    end else if (startNow) begin
      pendNext = 1'b0;
    end else if (trigEdge) begin
      pendNext = 1'b1;
    end else begin
      pendNext = pending;
    end

    xferReq   = running & (~reqEn | perReq);
    burstDone = doneQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_IDLE;
      pending <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= pendNext;
      doneQ   <= lastXfer;
    end
  end

  // R3
  pace_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (reqEn && !perReq) |-> !xferReq);

  // R9
  pend_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(trigEdge));

  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && xferDone) |=> !burstDone);

  // R2
  start_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(chanEnable));

endmodule

// File: rtl/dma_pace_unit.sv
module dma_pace_unit
  import pace_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chanEnable,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             perReq,
  input  logic             hwTrig,
  input  logic             xferDone,
  output logic             xferReq,
  output logic             burstDone
);

  paceCfg_t    cfg;
  ctrlStrobe_t strobe;
  logic        trigActive;
  logic        trigEdge;
  logic        cntZero;

  assign cfg = paceCfg_t'(cfgWord);

  pace_trig #(.SYNC_STAGES(SYNC_STAGES)) trig_i (
    .clk        (clk),
    .rst        (rst),
    .hwTrig     (hwTrig),
    .polHigh    (cfg.polHigh),
    .trigActive (trigActive),
    .trigEdge   (trigEdge)
  );

  pace_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .chanEnable (chanEnable),
    .reqEn      (cfg.reqEn),
    .trigEn     (cfg.trigEn),
    .levelMode  (cfg.levelMode),
    .perReq     (perReq),
    .xferDone   (xferDone),
    .trigActive (trigActive),
    .trigEdge   (trigEdge),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .xferReq    (xferReq),
    .burstDone  (burstDone)
  );

  pace_count #(.CNT_W(CNT_W), .XP_W(EXP_W)) count_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .burstMode (cfg.burstMode),
    .burstExp  (cfg.burstExp),
    .cntZero   (cntZero)
  );

  // R8
  burst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    burstDone |=> !burstDone);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    burstDone |-> !xferReq);

endmodule

// File: tb/dma_pace_unit_tb_top.sv
module dma_pace_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       chanEnable;
  logic [7:0] cfgWord;
  logic       perReq;
  logic       hwTrig;
  logic       xferDone;
  logic       xferReq;
  logic       burstDone;

  int    nRun  = 0;
  int    nFail = 0;
  string curTag = "R1";
  bit    moverOn = 0;
  int    moverRate = 100;

  // bench cycle model state
  int sinceRst;
  bit mS0, mS1, mPrev, mRun, mPend, mDone;
  int mCnt;

  always #10 clk = ~clk;

  dma_pace_unit dut_i (
    .clk(clk), .rst(rst), .chanEnable(chanEnable), .cfgWord(cfgWord),
    .perReq(perReq), .hwTrig(hwTrig), .xferDone(xferDone),
    .xferReq(xferReq), .burstDone(burstDone)
  );

  function automatic bit expReq();
    return mRun && (!cfgWord[0] || perReq);
  endfunction

  task automatic modelStep();
    bit primed, act, ev, trigOk, start, last;
    if (rst) begin
      sinceRst = 0; mS0 = 0; mS1 = 0; mPrev = 0;
      mRun = 0; mPend = 0; mDone = 0; mCnt = 0;
    end else begin
      primed = (sinceRst >= 3);
      act    = primed && (cfgWord[2] ? mS1 : !mS1);
      ev     = primed && (cfgWord[2] ? (mS1 && !mPrev) : (!mS1 && mPrev));
      if (!cfgWord[1])     trigOk = 1;
      else if (cfgWord[3]) trigOk = act;
      else                 trigOk = ev || mPend;
      start = !mRun && chanEnable && trigOk;
      last  = mRun && xferDone && (mCnt == 0);
      if (!cfgWord[1] || cfgWord[3]) mPend = 0;
      else if (start)                mPend = 0;
      else if (ev)                   mPend = 1;
      if (start) mCnt = cfgWord[4] ? ((1 << cfgWord[7:5]) - 1) : 0;
      else if (mRun && xferDone && mCnt != 0) mCnt = mCnt - 1;
      mDone = last;
      if (start) mRun = 1;
      else if (last) mRun = 0;
      mPrev = mS1; mS1 = mS0; mS0 = hwTrig;
      sinceRst++;
    end
  endtask

  task automatic checkVal(string tag, string what, int got, int exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkVal(curTag, "xferReq", int'(xferReq), int'(expReq()));
    checkVal(curTag, "burstDone", int'(burstDone), int'(mDone));
    if (moverOn) xferDone = xferReq && (($urandom % 100) < moverRate);
  endtask

  task automatic doReset();
    rst = 1; xferDone = 0;
    repeat (3) cycle();
    rst = 0;
    cycle();
  endtask

  task automatic runUntilDone(int nDone, int limit, output int xfers, output int dones);
    xfers = 0; dones = 0;
    for (int i = 0; i < limit && dones < nDone; i++) begin
      cycle();
      if (burstDone) dones++;
      if (xferDone) xfers++;
    end
  endtask

  task automatic trigBurst(logic [7:0] cfg, int expXfers, string tag);
    int x, d;
    curTag = tag;
    cfgWord = cfg; chanEnable = 1; hwTrig = 0; moverOn = 0;
    doReset();
    repeat (4) cycle();
    hwTrig = 1; moverOn = 1; moverRate = 100;
    runUntilDone(1, 600, x, d);
    checkVal(tag, "transfers per unit", x, expXfers);
    checkVal(tag, "completion pulses", d, 1);
    hwTrig = 0; moverOn = 0; xferDone = 0;
  endtask

  initial begin
    int x, d, hi;
    void'($urandom(32'd20240611));
    rst = 1; chanEnable = 0; cfgWord = 8'h00; perReq = 0; hwTrig = 0; xferDone = 0;

    // R1 reset state
    curTag = "R1";
    doReset();
    checkVal("R1", "xferReq after reset", int'(xferReq), 0);
    checkVal("R1", "burstDone after reset", int'(burstDone), 0);

    // R5 warm-up: trigger already high through reset, rising mode
    curTag = "R5";
    cfgWord = 8'h06; chanEnable = 1; hwTrig = 1;
    doReset();
    hi = 0;
    for (int i = 0; i < 8; i++) begin cycle(); if (xferReq) hi++; end
    checkVal("R5", "no start from reset level", hi, 0);

    // R5 rising edge latency
    hwTrig = 0;
    doReset();
    repeat (4) cycle();
    hwTrig = 1;
    cycle(); checkVal("R5", "req edge+1", int'(xferReq), 0);
    cycle(); checkVal("R5", "req edge+2", int'(xferReq), 0);
    cycle(); checkVal("R5", "req edge+3", int'(xferReq), 1);
    moverOn = 1; moverRate = 100;
    runUntilDone(1, 20, x, d);
    checkVal("R7", "single transfer", x, 1);
    moverOn = 0; xferDone = 0;

    // R5 falling edge
    cfgWord = 8'h02; hwTrig = 1;
    doReset();
    repeat (4) cycle();
    checkVal("R5", "idle before fall", int'(xferReq), 0);
    hwTrig = 0;
    cycle(); cycle();
    checkVal("R5", "fall edge+2", int'(xferReq), 0);
    cycle();
    checkVal("R5", "fall edge+3", int'(xferReq), 1);

    // R7 burst lengths
    trigBurst(8'h76, 8, "R7");
    trigBurst(8'hF6, 128, "R7");
    trigBurst(8'hE6, 1, "R7");

    // R9 edge during a stalled burst becomes pending
    curTag = "R9";
    cfgWord = 8'h56; chanEnable = 1; hwTrig = 0; moverOn = 0;
    doReset();
    repeat (4) cycle();
    hwTrig = 1; repeat (5) cycle();
    hwTrig = 0; repeat (4) cycle();
    hwTrig = 1; repeat (5) cycle();
    moverOn = 1; moverRate = 100;
    runUntilDone(2, 100, x, d);
    checkVal("R9", "transfers over two bursts", x, 8);
    checkVal("R9", "completion pulses", d, 2);
    hi = 0;
    for (int i = 0; i < 15; i++) begin cycle(); if (xferReq) hi++; end
    checkVal("R9", "no third burst", hi, 0);
    moverOn = 0; xferDone = 0;

    // R6 level mode, active high then low
    curTag = "R6";
    cfgWord = 8'h0E; hwTrig = 0;
    doReset();
    repeat (4) cycle();
    hwTrig = 1; moverOn = 1; moverRate = 100;
    d = 0;
    for (int i = 0; i < 30; i++) begin cycle(); if (burstDone) d++; end
    checkVal("R6", "restarts while level holds", int'(d >= 10), 1);
    hwTrig = 0;
    repeat (6) cycle();
    hi = 0;
    for (int i = 0; i < 10; i++) begin cycle(); if (xferReq) hi++; end
    checkVal("R6", "stops after level drops", hi, 0);
    moverOn = 0; xferDone = 0;
    cfgWord = 8'h0A; hwTrig = 0;
    doReset();
    repeat (4) cycle();
    checkVal("R6", "active-low level starts", int'(xferReq), 1);

    // R3 request pacing
    curTag = "R3";
    cfgWord = 8'h01; perReq = 0; hwTrig = 0;
    doReset();
    repeat (3) cycle();
    checkVal("R3", "held off by perReq low", int'(xferReq), 0);
    perReq = 1; cycle();
    checkVal("R3", "released by perReq high", int'(xferReq), 1);

    // R2 channel enable, R4 trigger ignored when disabled
    curTag = "R2";
    cfgWord = 8'h00; chanEnable = 0; perReq = 0;
    doReset();
    repeat (4) cycle();
    checkVal("R2", "no start while disabled", int'(xferReq), 0);
    chanEnable = 1; cycle();
    checkVal("R2", "start once enabled", int'(xferReq), 1);
    curTag = "R4";
    cfgWord = 8'h04; hwTrig = 0;
    doReset();
    for (int i = 0; i < 10; i++) begin hwTrig = i[1]; cycle(); end
    checkVal("R4", "free run despite trigger", int'(xferReq), 1);

    // R10 idle xferDone pulses ignored
    curTag = "R10";
    cfgWord = 8'h36; hwTrig = 0; moverOn = 0;
    doReset();
    xferDone = 1;
    hi = 0;
    for (int i = 0; i < 3; i++) begin cycle(); if (xferReq || burstDone) hi++; end
    checkVal("R10", "idle done has no effect", hi, 0);
    xferDone = 0; cycle();
    hwTrig = 1; moverOn = 1; moverRate = 100;
    runUntilDone(1, 40, x, d);
    checkVal("R10", "next unit length intact", x, 2);
    moverOn = 0; xferDone = 0; hwTrig = 0;

    // Randomised segments against the cycle model
    curTag = "R8";
    doReset();
    moverOn = 1;
    for (int s = 0; s < 40; s++) begin
      cfgWord = 8'($urandom);
      if (s % 3 == 0) cfgWord[7:5] = 3'($urandom % 3);
      chanEnable = (($urandom % 8) != 0);
      moverRate = 20 + int'($urandom % 80);
      for (int c = 0; c < 200; c++) begin
        if (($urandom % 10) == 0) hwTrig = ~hwTrig;
        perReq = (($urandom % 10) < 7);
        if (!moverOn && ($urandom % 5) == 0) xferDone = 1;
        cycle();
      end
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule